// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store that sits beside a direct-mapped first-level cache and in front of the next memory level. When the first-level cache throws a line out, that line is written into the buffer together with its block address and a modified flag. When the first-level cache later misses, it presents the block address on the lookup port. Every stored entry compares its tag against that address in the same cycle. A hit hands the line back with its modified flag, so no slow fetch is needed. A miss raises a request to the next memory level that carries the same block address.

The tag is the whole block address, with the word-offset bits already removed, because a fully associative store has no index field. On a hit the matching entry is given up to the first-level cache. If the first-level cache inserts the line it displaced in the same cycle, that line lands in the freed slot, so the two lines are swapped. An insert that finds no room overwrites the oldest slot in turn. If that slot holds modified data, the data goes out as a writeback. The entry count is a parameter and may be set from 4 to 16.

Top module: `victim_cache`

## Requirements
- R1: After synchronous active-high reset every entry is invalid, so any lookup misses, and `wb_valid` is 0.
- R2: A lookup hits (`lkp_hit`=1) in the same cycle when a valid entry's tag equals `lkp_blk`. On a hit, `lkp_data` and `lkp_dirty` carry that entry's stored line and modified flag.
- R3: When `lkp_valid`=1 and no entry matches, `mem_req_valid`=1 in the same cycle with `mem_req_blk`=`lkp_blk`. `mem_req_valid` is 0 on a hit and when there is no lookup.
- R4: A hit invalidates the matching entry at the clock edge, so a repeated lookup of that block misses. The exception is an insert in the same cycle that writes into that slot.
- R5: An insert whose block address matches a valid entry overwrites that entry's line and modified flag. No second copy is created: after one later hit, the same block misses.
- R6: An insert that matches no entry picks its slot by priority. First comes the slot freed by a lookup hit in the same cycle. Next comes the lowest-numbered invalid slot. Otherwise the slot under a rotating oldest-first pointer is used; that pointer starts at 0 and advances by one (wrapping after ENTRIES-1) only when it is used.
- R7: When an insert overwrites a valid modified entry through the rotating pointer, `wb_valid`=1 in the next cycle only, with that entry's block address and line on `wb_blk`/`wb_data`. A clean entry that is overwritten produces no writeback.
- R8: At most one valid entry ever matches a given block address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Line evicted from the first-level cache is presented |
| ins_blk | input | 26 | Block address of the evicted line |
| ins_data | input | 64 | Evicted line contents |
| ins_dirty | input | 1 | Evicted line is modified |
| lkp_valid | input | 1 | Lookup after a first-level miss |
| lkp_blk | input | 26 | Block address looked up |
| lkp_hit | output | 1 | Lookup found the block |
| lkp_data | output | 64 | Line returned on a hit |
| lkp_dirty | output | 1 | Modified flag of the returned line |
| mem_req_valid | output | 1 | Lookup missed; fetch from next level |
| mem_req_blk | output | 26 | Block address to fetch |
| wb_valid | output | 1 | Modified line pushed out to next level |
| wb_blk | output | 26 | Block address of the writeback |
| wb_data | output | 64 | Line contents of the writeback |

## Verification
Lookup results (`lkp_hit`, `lkp_data`, `lkp_dirty`, `mem_req_valid`, `mem_req_blk`) are combinational, so the bench drives each cycle's inputs on the falling edge and samples them one nanosecond later, before the rising edge. Invalidation, overwrite and slot choice take effect at the rising edge, so they first show up in the next cycle's lookup. A writeback is registered and is compared in the sample that follows the displacing insert. A bench model applies the same slot-choice order at each rising edge and predicts every one of these values.

// File: rtl/vc_pkg.sv
package vc_pkg;
    localparam int unsigned VC_BLK_W  = 26;
    localparam int unsigned VC_LINE_W = 64;

    typedef logic [VC_BLK_W-1:0]  blk_t;
    typedef logic [VC_LINE_W-1:0] line_t;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        blk_t  blk;
        line_t data;
    } vc_entry_t;

    typedef struct packed {
        logic  valid;
        blk_t  blk;
        line_t data;
    } vc_wb_t;

    typedef enum logic [1:0] {
        SLOT_MATCH = 2'd0,
        SLOT_SWAP  = 2'd1,
        SLOT_FREE  = 2'd2,
        SLOT_FIFO  = 2'd3
    } slot_src_e;

    function automatic int unsigned vc_idx_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match
    import vc_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W = vc_idx_w(ENTRIES)
) (
    input  vc_entry_t [ENTRIES-1:0] ent,
    input  blk_t                    key,
    output logic [ENTRIES-1:0]      match_vec,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent[g].valid && (ent[g].blk == key);
    end

    assign any = |match_vec;

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc
    import vc_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W = vc_idx_w(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               ins_match,
    input  logic [IDX_W-1:0]   ins_match_idx,
    input  logic               lkp_hit,
    input  logic [IDX_W-1:0]   lkp_idx,
    input  logic [IDX_W-1:0]   fifo_ptr,
    output logic [IDX_W-1:0]   slot,
    output slot_src_e          src
);
    logic             have_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (ins_match) begin
            slot = ins_match_idx;
            src  = SLOT_MATCH;
        end else if (lkp_hit) begin
            slot = lkp_idx;
            src  = SLOT_SWAP;
        end else if (have_free) begin
            slot = free_idx;
            src  = SLOT_FREE;
        end else begin
            slot = fifo_ptr;
            src  = SLOT_FIFO;
        end
    end
endmodule

// File: rtl/victim_cache.sv
module victim_cache
    import vc_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W = vc_idx_w(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ins_valid,
    input  logic [VC_BLK_W-1:0]  ins_blk,
    input  logic [VC_LINE_W-1:0] ins_data,
    input  logic                 ins_dirty,
    input  logic                 lkp_valid,
    input  logic [VC_BLK_W-1:0]  lkp_blk,
    output logic                 lkp_hit,
    output logic [VC_LINE_W-1:0] lkp_data,
    output logic                 lkp_dirty,
    output logic                 mem_req_valid,
    output logic [VC_BLK_W-1:0]  mem_req_blk,
    output logic                 wb_valid,
    output logic [VC_BLK_W-1:0]  wb_blk,
    output logic [VC_LINE_W-1:0] wb_data
);
    vc_entry_t [ENTRIES-1:0] ent;
    logic [ENTRIES-1:0]      valid_vec;
    logic [ENTRIES-1:0]      lkp_vec;
    logic [ENTRIES-1:0]      ins_vec;
    logic                    lkp_any;
    logic                    ins_any;
    logic [IDX_W-1:0]        lkp_idx;
    logic [IDX_W-1:0]        ins_idx;
    logic [IDX_W-1:0]        fifo_ptr;
    logic [IDX_W-1:0]        slot;
    slot_src_e               src;
    vc_wb_t                  wb_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = ent[g].valid;
    end

    vc_tag_match #(.ENTRIES(ENTRIES)) u_lkp_match (
        .ent(ent), .key(lkp_blk), .match_vec(lkp_vec), .any(lkp_any), .idx(lkp_idx)
    );

    vc_tag_match #(.ENTRIES(ENTRIES)) u_ins_match (
        .ent(ent), .key(ins_blk), .match_vec(ins_vec), .any(ins_any), .idx(ins_idx)
    );

    vc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .valid_vec(valid_vec),
        .ins_match(ins_any),
        .ins_match_idx(ins_idx),
        .lkp_hit(lkp_hit),
        .lkp_idx(lkp_idx),
        .fifo_ptr(fifo_ptr),
        .slot(slot),
        .src(src)
    );

    assign lkp_hit       = lkp_valid && lkp_any;
    assign lkp_data      = ent[lkp_idx].data;
    assign lkp_dirty     = ent[lkp_idx].dirty;
    assign mem_req_valid = lkp_valid && !lkp_any;
    assign mem_req_blk   = lkp_blk;

    assign wb_valid = wb_q.valid;
    assign wb_blk   = wb_q.blk;
    assign wb_data  = wb_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent[i].valid <= 1'b0;
                ent[i].dirty <= 1'b0;
            end
            fifo_ptr <= '0;
            wb_q     <= '0;
        end else begin
            wb_q.valid <= 1'b0;
            if (lkp_hit) begin
                ent[lkp_idx].valid <= 1'b0;
            end
            if (ins_valid) begin
                ent[slot] <= '{valid: 1'b1, dirty: ins_dirty, blk: ins_blk, data: ins_data};
                if (src == SLOT_FIFO) begin
                    fifo_ptr <= (fifo_ptr == IDX_W'(ENTRIES - 1)) ? '0 : fifo_ptr + 1'b1;
                    if (ent[slot].valid && ent[slot].dirty) begin
                        wb_q <= '{valid: 1'b1, blk: ent[slot].blk, data: ent[slot].data};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned BLK_W   = 26
) (
    input logic               clk,
    input logic               rst,
    input logic               lkp_valid,
    input logic [BLK_W-1:0]   lkp_blk,
    input logic               lkp_hit,
    input logic               ins_valid,
    input logic               mem_req_valid,
    input logic               wb_valid,
    input logic [ENTRIES-1:0] lkp_vec,
    input logic [ENTRIES-1:0] ins_vec
);
    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> !wb_valid); // R1

    AST_HIT_HAS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        lkp_hit |-> (lkp_valid && !mem_req_valid)); // R2

    AST_HIT_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (lkp_hit && !ins_valid) |=> !(lkp_valid && lkp_hit && (lkp_blk == $past(lkp_blk)))); // R4

    AST_WB_AFTER_INSERT: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(ins_valid)); // R7

    AST_SINGLE_LKP_MATCH: assert property (@(posedge clk) disable iff (rst)
        $countones(lkp_vec) <= 1); // R8

    AST_SINGLE_INS_MATCH: assert property (@(posedge clk) disable iff (rst)
        $countones(ins_vec) <= 1); // R8
endmodule

bind victim_cache vc_checker #(.ENTRIES(ENTRIES), .BLK_W(vc_pkg::VC_BLK_W)) u_chk (
    .clk(clk),
    .rst(rst),
    .lkp_valid(lkp_valid),
    .lkp_blk(lkp_blk),
    .lkp_hit(lkp_hit),
    .ins_valid(ins_valid),
    .mem_req_valid(mem_req_valid),
    .wb_valid(wb_valid),
    .lkp_vec(lkp_vec),
    .ins_vec(ins_vec)
);

// File: tb/victim_cache_tb.sv
`timescale 1ns/1ps
module victim_cache_tb;
    import vc_pkg::*;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ins_valid = 1'b0, ins_dirty = 1'b0, lkp_valid = 1'b0;
    blk_t ins_blk = '0, lkp_blk = '0;
    line_t ins_data = '0;
    logic lkp_hit, lkp_dirty, mem_req_valid, wb_valid;
    line_t lkp_data, wb_data;
    blk_t mem_req_blk, wb_blk;

    always #4 clk = ~clk;

    victim_cache #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_blk(ins_blk), .ins_data(ins_data), .ins_dirty(ins_dirty),
        .lkp_valid(lkp_valid), .lkp_blk(lkp_blk),
        .lkp_hit(lkp_hit), .lkp_data(lkp_data), .lkp_dirty(lkp_dirty),
        .mem_req_valid(mem_req_valid), .mem_req_blk(mem_req_blk),
        .wb_valid(wb_valid), .wb_blk(wb_blk), .wb_data(wb_data)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    logic  m_v [N];
    logic  m_d [N];
    blk_t  m_b [N];
    line_t m_data [N];
    int    m_ptr;
    logic  e_wb;
    blk_t  e_wb_blk;
    line_t e_wb_data;
    logic  obs_hit, obs_wb;
    blk_t  obs_wb_blk;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_find(blk_t b);
        for (int i = 0; i < N; i++) if (m_v[i] && m_b[i] == b) return i;
        return -1;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    task automatic step(logic lv, blk_t lb, logic iv, blk_t ib, line_t idat, logic idt);
        int hi, mi, fr, slot;
        @(negedge clk);
        lkp_valid = lv; lkp_blk = lb;
        ins_valid = iv; ins_blk = ib; ins_data = idat; ins_dirty = idt;
        #1;
        hi = lv ? m_find(lb) : -1;
        chk("R2 hit", lkp_hit, hi >= 0);
        if (hi >= 0) begin
            chk("R2 data", lkp_data, m_data[hi]);
            chk("R2 dirty", lkp_dirty, m_d[hi]);
        end
        chk("R3 mem_req_valid", mem_req_valid, lv && hi < 0);
        if (lv && hi < 0) chk("R3 mem_req_blk", mem_req_blk, lb);
        chk("R7 wb_valid", wb_valid, e_wb);
        if (e_wb) begin
            chk("R7 wb_blk", wb_blk, e_wb_blk);
            chk("R7 wb_data", wb_data, e_wb_data);
        end
        obs_hit = lkp_hit; obs_wb = wb_valid; obs_wb_blk = wb_blk;
        // model of the clock edge
        e_wb = 1'b0;
        mi = iv ? m_find(ib) : -1;
        fr = m_free();
        if (hi >= 0) m_v[hi] = 1'b0;
        if (iv) begin
            if (mi >= 0) slot = mi;
            else if (hi >= 0) slot = hi;
            else if (fr >= 0) slot = fr;
            else begin
                slot = m_ptr;
                if (m_d[slot]) begin
                    e_wb = 1'b1; e_wb_blk = m_b[slot]; e_wb_data = m_data[slot];
                end
                m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
            end
            m_v[slot] = 1'b1; m_d[slot] = idt; m_b[slot] = ib; m_data[slot] = idat;
        end
        @(posedge clk);
    endtask

    function automatic line_t rl();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd4242;
        void'($urandom(seed));
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_b[i] = '0; m_data[i] = '0; end
        m_ptr = 0; e_wb = 0; e_wb_blk = '0; e_wb_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: nothing held after reset
        step(1, 26'd5, 0, '0, '0, 0);
        chk("R1 lookup after reset", obs_hit, 1'b0);
        chk("R1 wb after reset", obs_wb, 1'b0);

        // R6: fill with dirty lines 100..107, then push slot 0 out
        for (int i = 0; i < N; i++) step(0, '0, 1, blk_t'(100 + i), rl(), 1);
        step(0, '0, 1, 26'd200, rl(), 0);
        step(0, '0, 0, '0, '0, 0);
        chk("R6 oldest slot pushed", obs_wb_blk, 26'd100);
        chk("R7 dirty writeback", obs_wb, 1'b1);
        // pointer now 1: overwrite blk 101 (dirty) with clean 201
        step(0, '0, 1, 26'd201, rl(), 0);
        step(0, '0, 1, 26'd202, rl(), 0);
        chk("R6 pointer advanced", obs_wb_blk, 26'd101);

        // R5: overwrite an existing block, no duplicate
        step(0, '0, 1, 26'd200, 64'h1111_2222_3333_4444, 1);
        step(1, 26'd200, 0, '0, '0, 0);
        chk("R5 overwritten entry hits", obs_hit, 1'b1);
        step(1, 26'd200, 0, '0, '0, 0);
        chk("R5 no duplicate copy", obs_hit, 1'b0);
        // R4: hit consumed
        step(1, 26'd104, 0, '0, '0, 0);
        step(1, 26'd104, 0, '0, '0, 0);
        chk("R4 entry invalidated after hit", obs_hit, 1'b0);
        // R4/R6: swap, the displaced line takes the hit slot
        step(1, 26'd105, 1, 26'd300, rl(), 1);
        chk("R4 swap lookup hit", obs_hit, 1'b1);
        step(1, 26'd300, 0, '0, '0, 0);
        chk("R6 swapped line present", obs_hit, 1'b1);

        // random phase with a narrow address range for reuse
        for (int c = 0; c < 3000; c++) begin
            step(($urandom % 10) < 6, blk_t'($urandom % 14),
                 ($urandom % 10) < 5, blk_t'($urandom % 14), rl(), $urandom % 2);
        end
        step(0, '0, 0, '0, '0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule